// File: doc/BRIEF.md
# Inactivity-Driven Power State Controller

The controller counts idle clock cycles and walks the system down through three reduced-power levels: light (doze), deeper (standby) and deepest (suspend). Each level has its own programmable 16-bit timeout. A level's timer starts only once the level above it has been entered. Each time a timer expires, the controller raises a management interrupt request. Firmware can act on that request and clears it with an acknowledge. System activity seen in any reduced level, or while suspend is pending, sends the controller straight back to full power. It also raises the interrupt so firmware can restore the machine.

Before the deepest level is reached, the controller asks the CPU to suspend. It waits for the CPU to acknowledge before it moves into suspend, which gives the core time to retire its current instruction and finish its bus cycles. In the two lighter levels, the suspend request can be duty-cycled to throttle the CPU. Board supply planes stay powered except in suspend, where only the planes selected by a keep mask remain on. A separate peripheral idle timer flags a lack of peripheral activity. It is independent of the system timers.

Top module: `pwr_idle_ctrl`

## Requirements
- R1: After reset, `pstate` is 0 (full power), `smi_req`, `cpu_susp_req` and `per_idle` are 0, and every bit of `plane_on` is 1.
- R2: The `pstate` encoding is 0 full, 1 doze, 2 standby, 3 suspend. From full power with no `sys_act`, `pstate` becomes 1 on the `doze_ld`-th rising clock edge. It is still 0 one edge earlier, and `smi_req` is set in the same edge that changes `pstate`.
- R3: The standby timer starts counting at doze entry. `pstate` becomes 2 exactly `stby_ld` edges after doze entry, and `smi_req` is set. Once `susp_ld` edges have passed in standby, `cpu_susp_req` goes to 1 and `smi_req` is set.
- R4: Suspend (`pstate` 3) is entered only on an edge where `cpu_susp_ack` is 1 while suspend is pending. Until then `pstate` stays 2 and `cpu_susp_req` stays 1.
- R5: A `sys_act` pulse clears the idle count and returns `pstate` to 0. If the state was not full power, or a suspend was pending, the pulse also sets `smi_req` and drops `cpu_susp_req`.
- R6: `smi_req` stays at 1 until an edge where `smi_ack` is 1 and no new cause occurs.
- R7: A timeout value of 0 disables that timer, so the current level is held indefinitely.
- R8: `plane_on` is all ones in every state except suspend, where it equals `plane_keep`.
- R9: In doze or standby with `thr_en`=1 and `thr_per`≠0, `cpu_susp_req` repeats a pattern of `thr_per` cycles. It is 1 for the first `thr_on` cycles of each period, with the pattern starting at state entry. In full power it is 0.
- R10: `per_idle` becomes 1 on the `per_ld`-th edge without `per_act`, and a `per_act` pulse clears it. `sys_act` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_act | input | 1 | System activity pulse |
| per_act | input | 1 | Peripheral activity pulse |
| doze_ld | input | CNT_W | Doze timeout in cycles (0 = off) |
| stby_ld | input | CNT_W | Standby timeout in cycles (0 = off) |
| susp_ld | input | CNT_W | Suspend timeout in cycles (0 = off) |
| per_ld | input | CNT_W | Peripheral idle timeout (0 = off) |
| smi_ack | input | 1 | Firmware acknowledge of the interrupt |
| cpu_susp_ack | input | 1 | CPU ready to be suspended |
| thr_en | input | 1 | Enable suspend-request throttling |
| thr_on | input | THR_W | Throttle asserted cycles per period |
| thr_per | input | THR_W | Throttle period in cycles |
| plane_keep | input | NPL | Planes left powered in suspend |
| pstate | output | 2 | Current power level |
| smi_req | output | 1 | Management interrupt request |
| cpu_susp_req | output | 1 | Suspend request to the CPU |
| plane_on | output | NPL | Supply plane enables |
| per_idle | output | 1 | Peripheral idle flag |

## Verification
The assertions assume that `sys_act` and `per_act` are single-cycle pulses sampled on the clock, and that the timeout inputs stay constant while a timer is counting. The bench changes reloads only while reset is held and changes pulses only on falling edges. Throttle settings are likewise fixed before reset is released, so each duty pattern begins cleanly at doze entry.

// File: rtl/pwr_idle_ctrl.sv
module pwr_idle_ctrl #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8,
  parameter int NPL   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_act,
  input  logic             per_act,
  input  logic [CNT_W-1:0] doze_ld,
  input  logic [CNT_W-1:0] stby_ld,
  input  logic [CNT_W-1:0] susp_ld,
  input  logic [CNT_W-1:0] per_ld,
  input  logic             smi_ack,
  input  logic             cpu_susp_ack,
  input  logic             thr_en,
  input  logic [THR_W-1:0] thr_on,
  input  logic [THR_W-1:0] thr_per,
  input  logic [NPL-1:0]   plane_keep,
  output logic [1:0]       pstate,
  output logic             smi_req,
  output logic             cpu_susp_req,
  output logic [NPL-1:0]   plane_on,
  output logic             per_idle
);

  typedef enum logic [1:0] {S_FULL = 2'd0, S_DOZE = 2'd1, S_STBY = 2'd2, S_SUSP = 2'd3} pst_t;

  pst_t             st;
  logic             pend;
  logic [CNT_W-1:0] cnt, pcnt, lim;
  logic [THR_W-1:0] ph;
  logic             expire, wake, thr_act;

  always_comb begin
    case (st)
      S_FULL:  lim = doze_ld;
      S_DOZE:  lim = stby_ld;
      S_STBY:  lim = susp_ld;
      default: lim = '0;
    endcase
  end

  assign expire  = !sys_act && !pend && st != S_SUSP && lim != '0 && cnt == lim - CNT_W'(1);
  assign wake    = sys_act && (st != S_FULL || pend);
  assign thr_act = thr_en && thr_per != '0 && (st == S_DOZE || st == S_STBY) && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_FULL;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (sys_act) begin
      st   <= S_FULL;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (pend) begin
      if (cpu_susp_ack) begin
        st   <= S_SUSP;
        pend <= 1'b0;
      end
    end else if (expire) begin
      cnt <= '0;
      if (st == S_STBY) pend <= 1'b1;
      else              st   <= pst_t'(st + 2'd1);
    end else if (st != S_SUSP && lim != '0) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                smi_req <= 1'b0;
    else if (expire || wake)   smi_req <= 1'b1;
    else if (smi_ack)          smi_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !thr_act || sys_act || expire) ph <= '0;
    else if (ph == thr_per - THR_W'(1))          ph <= '0;
    else                                         ph <= ph + THR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || per_act) begin
      pcnt     <= '0;
      per_idle <= 1'b0;
    end else if (!per_idle && per_ld != '0) begin
      if (pcnt == per_ld - CNT_W'(1)) begin
        pcnt     <= '0;
        per_idle <= 1'b1;
      end else begin
        pcnt <= pcnt + CNT_W'(1);
      end
    end
  end

  assign pstate       = st;
  assign cpu_susp_req = st == S_SUSP || pend || (thr_act && ph < thr_on);
  assign plane_on     = (st == S_SUSP) ? plane_keep : {NPL{1'b1}};

  p_susp_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3 && $past(pstate) != 2'd3) |-> $past(cpu_susp_ack));

  p_step_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != $past(pstate)) |-> (pstate == 2'd0 || pstate == $past(pstate) + 2'd1));

  p_wake_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_act |=> (pstate == 2'd0 && !cpu_susp_req));

  p_wake_smi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_act && (pstate != 2'd0 || cpu_susp_req)) |=> smi_req);

  p_smi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smi_ack) |=> smi_req);

  p_per_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_act |=> !per_idle);

  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd2 && cpu_susp_req && !thr_en && !sys_act && !cpu_susp_ack) |=> (pstate == 2'd2 && cpu_susp_req));

endmodule

// File: tb/sim_pwr_idle_ctrl.sv
module sim_pwr_idle_ctrl;
  localparam int NPL = 4;

  logic clk = 1'b0;
  logic rst_n, sys_act, per_act, smi_ack, cpu_susp_ack, thr_en;
  logic [15:0] doze_ld, stby_ld, susp_ld, per_ld;
  logic [7:0]  thr_on, thr_per;
  logic [NPL-1:0] plane_keep, plane_on;
  logic [1:0] pstate;
  logic smi_req, cpu_susp_req, per_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_idle_ctrl u0 (
    .clk, .rst_n, .sys_act, .per_act, .doze_ld, .stby_ld, .susp_ld, .per_ld,
    .smi_ack, .cpu_susp_ack, .thr_en, .thr_on, .thr_per, .plane_keep,
    .pstate, .smi_req, .cpu_susp_req, .plane_on, .per_idle
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input int dz, input int sb, input int sp, input int pp);
    @(negedge clk);
    rst_n = 1'b0; sys_act = 0; per_act = 0; smi_ack = 0; cpu_susp_ack = 0;
    doze_ld = 16'(dz); stby_ld = 16'(sb); susp_ld = 16'(sp); per_ld = 16'(pp);
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_act();
    sys_act = 1'b1; tick(1); sys_act = 1'b0;
  endtask

  task automatic ack_smi();
    smi_ack = 1'b1; tick(1); smi_ack = 1'b0;
  endtask

  task automatic t_reset();
    thr_en = 0; plane_keep = 4'b0101;
    restart(0, 0, 0, 0);
    tick(1);
    chk("R1 pstate", pstate, 0);
    chk("R1 smi_req", smi_req, 0);
    chk("R1 cpu_susp_req", cpu_susp_req, 0);
    chk("R1 per_idle", per_idle, 0);
    chk("R1 plane_on", plane_on, 15);
  endtask

  task automatic t_doze();
    restart(5, 0, 0, 0);
    tick(4);
    chk("R2 before doze", pstate, 0);
    chk("R2 smi quiet", smi_req, 0);
    tick(1);
    chk("R2 doze entry", pstate, 1);
    chk("R2 smi on doze", smi_req, 1);
    tick(3);
    chk("R6 smi held", smi_req, 1);
    ack_smi();
    chk("R6 smi cleared", smi_req, 0);
    tick(20);
    chk("R7 standby disabled", pstate, 1);
  endtask

  task automatic t_cascade();
    restart(3, 4, 2, 0);
    tick(3);
    chk("R2 doze", pstate, 1);
    ack_smi();
    tick(2);
    chk("R3 still doze", pstate, 1);
    tick(1);
    chk("R3 standby", pstate, 2);
    chk("R3 smi standby", smi_req, 1);
    chk("R3 no req yet", cpu_susp_req, 0);
    ack_smi();
    tick(1);
    chk("R3 susp request", cpu_susp_req, 1);
    chk("R3 smi on susp timer", smi_req, 1);
    ack_smi();
    tick(5);
    chk("R4 held standby", pstate, 2);
    chk("R4 req held", cpu_susp_req, 1);
    chk("R8 planes before susp", plane_on, 15);
    cpu_susp_ack = 1'b1; tick(1); cpu_susp_ack = 1'b0;
    chk("R4 suspend", pstate, 3);
    chk("R8 planes in susp", plane_on, 5);
    chk("R6 smi clear in susp", smi_req, 0);
    tick(10);
    chk("R4 stays suspended", pstate, 3);
    pulse_act();
    chk("R5 wake state", pstate, 0);
    chk("R5 wake smi", smi_req, 1);
    chk("R5 wake req drop", cpu_susp_req, 0);
    chk("R8 planes restored", plane_on, 15);
  endtask

  task automatic t_act_restart();
    restart(6, 0, 0, 0);
    tick(4);
    pulse_act();
    chk("R5 full after act", pstate, 0);
    chk("R5 no smi in full", smi_req, 0);
    tick(5);
    chk("R5 count restarted", pstate, 0);
    tick(1);
    chk("R5 doze after restart", pstate, 1);
  endtask

  task automatic t_pend_abort();
    restart(1, 1, 1, 0);
    tick(3);
    chk("R3 pending", cpu_susp_req, 1);
    ack_smi();
    chk("R4 no ack no susp", pstate, 2);
    pulse_act();
    chk("R5 abort state", pstate, 0);
    chk("R5 abort req", cpu_susp_req, 0);
    chk("R5 abort smi", smi_req, 1);
  endtask

  task automatic t_throttle();
    thr_en = 1; thr_on = 8'd2; thr_per = 8'd4;
    restart(2, 0, 0, 0);
    tick(1);
    chk("R9 full no req", cpu_susp_req, 0);
    tick(1);
    chk("R9 doze", pstate, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R9 duty", cpu_susp_req, (i % 4) < 2 ? 1 : 0);
      tick(1);
    end
    thr_en = 0;
  endtask

  task automatic t_periph();
    restart(0, 0, 0, 3);
    tick(2);
    chk("R10 not yet idle", per_idle, 0);
    tick(1);
    chk("R10 idle", per_idle, 1);
    pulse_act();
    chk("R10 sys_act ignored", per_idle, 1);
    per_act = 1'b1; tick(1); per_act = 1'b0;
    chk("R10 cleared", per_idle, 0);
    tick(2);
    chk("R10 recount", per_idle, 0);
    tick(1);
    chk("R10 idle again", per_idle, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sys_act = 0; per_act = 0; smi_ack = 0; cpu_susp_ack = 0;
    thr_en = 0; thr_on = 0; thr_per = 0; plane_keep = 4'b0101;
    doze_ld = 0; stby_ld = 0; susp_ld = 0; per_ld = 0;
    t_reset();
    t_doze();
    t_cascade();
    t_act_restart();
    t_pend_abort();
    t_throttle();
    t_periph();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule